// File: doc/BRIEF.md
# Differential Sync Acquisition Receiver

This block sits behind a bit-clock recovery stage and takes one raw channel bit per `bit_valid` strobe. It hunts for a run of zeros ending in a single one, then locks onto a 40-bit sync word. Matching is done by a correlator that tolerates bit errors and also accepts the bitwise inverse of the word. Once the receiver is aligned, each raw bit is turned into a data bit by differential decoding. The data polarity is set by whichever sync match won.

Fourteen data bytes are gathered and offered to an external decoder, which handles deinterleaving, error correction and the CRC check. The decoder answers with an acknowledge, a pass/fail flag and the extracted fields. A pass latches the fields and raises a one-cycle `packet_valid`. A fail produces no output. In both cases the receiver clears its state and starts hunting again.

Top module: `diffsync_rx`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `packet_valid`, `dec_req`, `op`, `arg` and `unit_id` are all zero.
- R2: In the hunt state the data bit equals the raw bit. Lock on the preamble needs two things: at least 20 bits counted since the last clear, and the newest 20 data bits reading nineteen zeros followed by a one. With 18 zeros plus the one (19 bits after a clear) there is no lock. With 19 zeros plus the one there is a lock.
- R3: From the preamble's final one onward, each data bit is the previous data bit XOR the raw bit, with the previous bit seeded to 1. The 14 collected bytes appear on `dec_block`. Byte k occupies bits [8k+7:8k], and the first-received bit of each byte sits in bit 7 of its byte.
- R4: Sync is accepted when the newest 40 data bits agree with 0x07092A446F in at least 32 positions. Eight wrong bits still lock. Nine wrong bits do not lock.
- R5: If the 40 bits agree better with the inverse of the sync word (again at least 32 agreeing positions), every later data bit is additionally inverted. The payload is then recovered unchanged.
- R6: `dec_req` rises right after the edge that takes the 112th data bit after sync. It stays high until `dec_ack`. While it is high, `dec_block` is frozen and incoming bits are ignored.
- R7: An ack with `dec_crc_ok` high loads `op`, `arg` and `unit_id` from the decoder and raises `packet_valid` for exactly the one cycle after the ack edge. `dec_req` drops in that same cycle.
- R8: An ack with `dec_crc_ok` low gives no pulse and leaves the fields unchanged. The receiver returns to hunting, so a following frame is received normally.
- R9: `op`, `arg` and `unit_id` change only together with a `packet_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_in | input | 1 | Raw channel bit |
| bit_valid | input | 1 | Strobe: `bit_in` carries a new bit this cycle |
| dec_req | output | 1 | Collected block is ready for the decoder |
| dec_block | output | 112 | Fourteen collected bytes, byte 0 in the low bits |
| dec_ack | input | 1 | Decoder has finished with the block |
| dec_crc_ok | input | 1 | Decoder found a valid CRC (sampled with `dec_ack`) |
| dec_op | input | 8 | Opcode from the decoder |
| dec_arg | input | 8 | Argument from the decoder |
| dec_unit_id | input | 16 | Unit identifier from the decoder |
| packet_valid | output | 1 | One-cycle pulse when new fields are loaded |
| op | output | 8 | Held opcode |
| arg | output | 8 | Held argument |
| unit_id | output | 16 | Held unit identifier |

## Verification
Each bit is taken on the clock edge that sees its strobe. `dec_req` and `dec_block` are therefore checked at the falling edge right after the strobe of the last payload bit, with no extra latency. The fields and `packet_valid` are checked one falling edge after the ack strobe, and the next falling edge confirms that the pulse has ended. The bench sweeps 0 to 9 sync bit errors in both polarities and builds every raw stream from the inverse of the differential rule. The preamble length is checked on both sides of its 20-bit boundary.

// File: rtl/diffsync_pkg.sv
package diffsync_pkg;
  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_ALIGN   = 2'd1,
    ST_GATHER  = 2'd2,
    ST_HANDOFF = 2'd3
  } rx_state_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/diffsync_front.sv
// Data-bit recovery and bit history.
module diffsync_front #(
  parameter int unsigned HIST_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              shift_en_i,
  input  logic              diff_mode_i,
  input  logic              raw_bit_i,
  input  logic              seed_one_i,
  input  logic              inv_load_i,
  input  logic              inv_val_i,
  output logic [HIST_W-1:0] hist_nxt_o
);
  logic              dec_q, dec_d;
  logic              inv_q, inv_d;
  logic [HIST_W-1:0] hist_q, hist_d;
  logic              data_bit;

  always_comb begin
    data_bit   = diff_mode_i ? (dec_q ^ raw_bit_i ^ inv_q) : raw_bit_i;
    hist_nxt_o = {hist_q[HIST_W-2:0], data_bit};
  end

  always_comb begin
    hist_d = hist_q;
    dec_d  = dec_q;
    inv_d  = inv_q;
    if (clr_i) begin
      hist_d = '0;
      dec_d  = 1'b0;
      inv_d  = 1'b0;
    end else begin
      if (shift_en_i) begin
        hist_d = hist_nxt_o;
        dec_d  = seed_one_i ? 1'b1 : data_bit;
      end
      if (inv_load_i) inv_d = inv_val_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      dec_q  <= 1'b0;
      inv_q  <= 1'b0;
    end else begin
      hist_q <= hist_d;
      dec_q  <= dec_d;
      inv_q  <= inv_d;
    end
  end

  AST_SEED_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en_i && seed_one_i && !clr_i) |=> dec_q) else $error("seed"); // R3
endmodule

// File: rtl/diffsync_corr.sv
// Error-tolerant sync correlator, true and inverted.
module diffsync_corr #(
  parameter int unsigned      LEN  = 40,
  parameter logic [LEN-1:0]   WORD = 40'h07092A446F,
  parameter int unsigned      THR  = 32
) (
  input  logic [LEN-1:0] win_i,
  output logic           hit_o,
  output logic           inv_win_o
);
  localparam int unsigned PC_W = $clog2(LEN + 1);

  logic [LEN-1:0]  agree;
  logic [PC_W-1:0] true_cnt;
  logic [PC_W-1:0] inv_cnt;

  always_comb begin
    agree    = ~(win_i ^ WORD);
    true_cnt = '0;
    for (int i = 0; i < LEN; i++) begin
      true_cnt = true_cnt + {{(PC_W-1){1'b0}}, agree[i]};
    end
    inv_cnt   = PC_W'(LEN) - true_cnt;
    hit_o     = (true_cnt >= PC_W'(THR)) || (inv_cnt >= PC_W'(THR));
    inv_win_o = inv_cnt > true_cnt;
  end
endmodule

// File: rtl/diffsync_gather.sv
// Byte slots filled in arrival order.
module diffsync_gather #(
  parameter int unsigned NBYTES = 14
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_i,
  input  logic                  wr_en_i,
  input  logic [7:0]            wr_byte_i,
  output logic                  last_slot_o,
  output logic [8*NBYTES-1:0]   blk_o
);
  localparam int unsigned IDX_W = $clog2(NBYTES + 1);

  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (clr_i)        idx_d = '0;
    else if (wr_en_i) idx_d = idx_q + 1'b1;
    last_slot_o = (idx_q == IDX_W'(NBYTES - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  for (genvar g = 0; g < NBYTES; g++) begin : g_slot
    logic [7:0] slot_q;
    logic       slot_we;
    assign slot_we = wr_en_i && (idx_q == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (clr_i)   slot_q <= '0;
      else if (slot_we) slot_q <= wr_byte_i;
    end
    assign blk_o[8*g +: 8] = slot_q;
  end

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDX_W'(NBYTES)) else $error("idx"); // R6
  AST_NO_WRITE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q == IDX_W'(NBYTES)) |-> !wr_en_i) else $error("full"); // R6
endmodule

// File: rtl/diffsync_ctrl.sv
// Acquisition sequencer, bit counter and field latch.
module diffsync_ctrl
  import diffsync_pkg::*;
#(
  parameter int unsigned PRE_LEN  = 20,
  parameter int unsigned SYNC_THR = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_valid_i,
  input  logic [PRE_LEN-1:0] pre_win_i,
  input  logic               corr_hit_i,
  input  logic               corr_inv_i,
  input  logic               last_slot_i,
  input  logic               dec_ack_i,
  input  logic               dec_ok_i,
  input  logic [7:0]         dec_op_i,
  input  logic [7:0]         dec_arg_i,
  input  logic [15:0]        dec_uid_i,
  output logic               shift_en_o,
  output logic               diff_mode_o,
  output logic               seed_one_o,
  output logic               inv_load_o,
  output logic               inv_val_o,
  output logic               clr_o,
  output logic               wr_en_o,
  output logic               dec_req_o,
  output logic               pv_o,
  output logic [7:0]         op_o,
  output logic [7:0]         arg_o,
  output logic [15:0]        uid_o
);
  localparam int unsigned CNT_TOP = (SYNC_THR > PRE_LEN) ? SYNC_THR : PRE_LEN;
  localparam int unsigned CNT_W   = $clog2(CNT_TOP + 1);
  localparam logic [PRE_LEN-1:0] PRE_MARK = {{(PRE_LEN-1){1'b0}}, 1'b1};

  rx_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             pv_q, pv_d;
  logic             take, fld_we;

  always_comb begin
    take        = bit_valid_i && (st_q != ST_HANDOFF);
    cnt_inc     = (cnt_q == {CNT_W{1'b1}}) ? cnt_q : cnt_q + 1'b1;
    st_d        = st_q;
    cnt_d       = cnt_q;
    shift_en_o  = take;
    diff_mode_o = (st_q != ST_HUNT);
    seed_one_o  = 1'b0;
    inv_load_o  = 1'b0;
    inv_val_o   = corr_inv_i;
    clr_o       = 1'b0;
    wr_en_o     = 1'b0;
    pv_d        = 1'b0;
    fld_we      = 1'b0;
    case (st_q)
      ST_HUNT: if (take) begin
        cnt_d = cnt_inc;
        if (cnt_inc >= CNT_W'(PRE_LEN) && pre_win_i == PRE_MARK) begin
          st_d       = ST_ALIGN;
          cnt_d      = CNT_W'(1);
          seed_one_o = 1'b1;
        end
      end
      ST_ALIGN: if (take) begin
        cnt_d = cnt_inc;
        if (cnt_inc >= CNT_W'(SYNC_THR) && corr_hit_i) begin
          st_d       = ST_GATHER;
          cnt_d      = '0;
          inv_load_o = 1'b1;
        end
      end
      ST_GATHER: if (take) begin
        if (cnt_inc == CNT_W'(8)) begin
          cnt_d   = '0;
          wr_en_o = 1'b1;
          if (last_slot_i) st_d = ST_HANDOFF;
        end else begin
          cnt_d = cnt_inc;
        end
      end
      default: if (dec_ack_i) begin
        clr_o  = 1'b1;
        st_d   = ST_HUNT;
        cnt_d  = '0;
        pv_d   = dec_ok_i;
        fld_we = dec_ok_i;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_HUNT;
      cnt_q <= '0;
      pv_q  <= 1'b0;
      op_o  <= '0;
      arg_o <= '0;
      uid_o <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      pv_q  <= pv_d;
      if (fld_we) begin
        op_o  <= dec_op_i;
        arg_o <= dec_arg_i;
        uid_o <= dec_uid_i;
      end
    end
  end

  assign dec_req_o = (st_q == ST_HANDOFF);
  assign pv_o      = pv_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pv_o |=> !pv_o) else $error("pulse"); // R7
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_req_o && !dec_ack_i) |=> dec_req_o) else $error("req"); // R6
  AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_req_o && dec_ack_i) |=> (!dec_req_o && (pv_o == $past(dec_ok_i)))) else $error("ack"); // R8
  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ({op_o, arg_o, uid_o} != $past({op_o, arg_o, uid_o})) |-> pv_o) else $error("hold"); // R9
endmodule

// File: rtl/diffsync_rx.sv
module diffsync_rx
  import diffsync_pkg::*;
#(
  parameter int unsigned          PRE_LEN   = 20,
  parameter int unsigned          SYNC_LEN  = 40,
  parameter logic [SYNC_LEN-1:0]  SYNC_WORD = 40'h07092A446F,
  parameter int unsigned          SYNC_THR  = 32,
  parameter int unsigned          NBYTES    = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bit_in,
  input  logic                    bit_valid,
  output logic                    dec_req,
  output logic [8*NBYTES-1:0]     dec_block,
  input  logic                    dec_ack,
  input  logic                    dec_crc_ok,
  input  logic [7:0]              dec_op,
  input  logic [7:0]              dec_arg,
  input  logic [15:0]             dec_unit_id,
  output logic                    packet_valid,
  output logic [7:0]              op,
  output logic [7:0]              arg,
  output logic [15:0]             unit_id
);
  localparam int unsigned HIST_W = (SYNC_LEN > PRE_LEN) ? SYNC_LEN : PRE_LEN;

  logic [HIST_W-1:0] hist_nxt;
  logic shift_en, diff_mode, seed_one, inv_load, inv_val, clr, wr_en;
  logic corr_hit, corr_inv, last_slot;

  diffsync_front #(.HIST_W(HIST_W)) u_front (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .shift_en_i(shift_en),
    .diff_mode_i(diff_mode), .raw_bit_i(bit_in), .seed_one_i(seed_one),
    .inv_load_i(inv_load), .inv_val_i(inv_val), .hist_nxt_o(hist_nxt)
  );

  diffsync_corr #(.LEN(SYNC_LEN), .WORD(SYNC_WORD), .THR(SYNC_THR)) u_corr (
    .win_i(hist_nxt[SYNC_LEN-1:0]), .hit_o(corr_hit), .inv_win_o(corr_inv)
  );

  diffsync_gather #(.NBYTES(NBYTES)) u_gather (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .wr_en_i(wr_en),
    .wr_byte_i(hist_nxt[BYTE_W-1:0]), .last_slot_o(last_slot), .blk_o(dec_block)
  );

  diffsync_ctrl #(.PRE_LEN(PRE_LEN), .SYNC_THR(SYNC_THR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .bit_valid_i(bit_valid),
    .pre_win_i(hist_nxt[PRE_LEN-1:0]), .corr_hit_i(corr_hit), .corr_inv_i(corr_inv),
    .last_slot_i(last_slot), .dec_ack_i(dec_ack), .dec_ok_i(dec_crc_ok),
    .dec_op_i(dec_op), .dec_arg_i(dec_arg), .dec_uid_i(dec_unit_id),
    .shift_en_o(shift_en), .diff_mode_o(diff_mode), .seed_one_o(seed_one),
    .inv_load_o(inv_load), .inv_val_o(inv_val), .clr_o(clr), .wr_en_o(wr_en),
    .dec_req_o(dec_req), .pv_o(packet_valid), .op_o(op), .arg_o(arg), .uid_o(unit_id)
  );

  AST_BLOCK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_req && $past(dec_req)) |-> $stable(dec_block)) else $error("blk"); // R6
endmodule

// File: tb/diffsync_rx_bench.sv
`timescale 1ns/1ps
module diffsync_rx_bench;
  localparam logic [39:0] SYNC = 40'h07092A446F;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst_n, bit_in, bit_valid, dec_ack, dec_crc_ok;
  logic [7:0]   dec_op, dec_arg;
  logic [15:0]  dec_unit_id;
  logic         dec_req, packet_valid;
  logic [111:0] dec_block;
  logic [7:0]   op, arg;
  logic [15:0]  unit_id;

  diffsync_rx u_diffsync_rx (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_valid(bit_valid),
    .dec_req(dec_req), .dec_block(dec_block), .dec_ack(dec_ack),
    .dec_crc_ok(dec_crc_ok), .dec_op(dec_op), .dec_arg(dec_arg),
    .dec_unit_id(dec_unit_id), .packet_valid(packet_valid),
    .op(op), .arg(arg), .unit_id(unit_id)
  );

  int errors = 0;
  int checks = 0;
  logic         dprev;
  logic [111:0] exp_blk;
  logic [31:0]  exp_fld;

  task automatic check(input bit ok, input string tag,
                       input logic [111:0] act, input logic [111:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_raw(input logic b);
    @(negedge clk); bit_in = b; bit_valid = 1'b1;
    @(negedge clk); bit_valid = 1'b0;
  endtask

  // inverse of the differential rule
  task automatic send_dec(input logic x, input logic inv);
    logic r;
    r = x ^ dprev ^ inv;
    dprev = x;
    send_raw(r);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    exp_fld = '0;
  endtask

  task automatic frame(input int nzero, input int nerr, input logic pol, input int seed);
    logic [7:0] b;
    for (int i = 0; i < nzero; i++) send_raw(1'b0);
    send_raw(1'b1);
    dprev = 1'b1;
    for (int i = 0; i < 40; i++) send_dec(SYNC[39-i] ^ pol ^ (i < nerr), 1'b0);
    for (int k = 0; k < 14; k++) begin
      b = 8'((seed * 53 + k * 29 + 17) ^ (k << 4));
      exp_blk[8*k +: 8] = b;
      for (int j = 7; j >= 0; j--) send_dec(b[j], pol);
    end
  endtask

  task automatic ack(input logic ok, input int seed);
    logic [31:0] f;
    f = {8'(seed), 8'(~seed), 8'(seed * 7), 8'h5A};
    @(negedge clk);
    dec_ack = 1'b1; dec_crc_ok = ok;
    dec_op = f[31:24]; dec_arg = f[23:16]; dec_unit_id = f[15:0];
    @(negedge clk);
    dec_ack = 1'b0;
    if (ok) exp_fld = f;
    check(packet_valid == ok, ok ? "R7 pulse after passing ack" : "R8 no pulse on failed ack",
          112'(packet_valid), 112'(ok));
    check({op, arg, unit_id} == exp_fld, ok ? "R7 fields loaded" : "R8 fields unchanged",
          112'({op, arg, unit_id}), 112'(exp_fld));
    check(dec_req == 1'b0, "R8 request released after ack", 112'(dec_req), 112'(0));
    @(negedge clk);
    check(packet_valid == 1'b0, "R7 pulse lasts one cycle", 112'(packet_valid), 112'(0));
  endtask

  task automatic locked_frame(input int nzero, input int nerr, input logic pol,
                              input int seed, input logic ok);
    logic [111:0] held;
    frame(nzero, nerr, pol, seed);
    check(dec_req == 1'b1, pol ? "R5 inverted sync locks" : "R4 sync locks within tolerance",
          112'(dec_req), 112'(1));
    check(dec_block == exp_blk, pol ? "R5 payload recovered" : "R3 payload recovered",
          dec_block, exp_blk);
    check({op, arg, unit_id} == exp_fld, "R9 fields held before ack",
          112'({op, arg, unit_id}), 112'(exp_fld));
    held = dec_block;
    for (int i = 0; i < 10; i++) send_raw(1'(i & 1));
    check(dec_req == 1'b1 && dec_block == held, "R6 block frozen while waiting",
          dec_block, held);
    ack(ok, seed);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bit_in = 1'b0; bit_valid = 1'b0;
    dec_ack = 1'b0; dec_crc_ok = 1'b0; dec_op = '0; dec_arg = '0; dec_unit_id = '0;
    dprev = 1'b0; exp_blk = '0; exp_fld = '0;
    repeat (3) @(negedge clk);
    check(packet_valid == 0 && dec_req == 0, "R1 outputs low in reset",
          112'({packet_valid, dec_req}), 112'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check({op, arg, unit_id} == 32'h0, "R1 fields zero after reset",
          112'({op, arg, unit_id}), 112'(0));
    check(dec_req == 0 && packet_valid == 0, "R1 no request after reset",
          112'({packet_valid, dec_req}), 112'(0));

    // preamble boundary: 19 bits after clear is too short
    frame(18, 0, 1'b0, 1);
    check(dec_req == 1'b0, "R2 short preamble rejected", 112'(dec_req), 112'(0));
    do_reset();
    // exactly 20 bits locks
    locked_frame(19, 0, 1'b0, 2, 1'b1);

    // sweep of sync bit errors in both polarities
    for (int p = 0; p < 2; p++) begin
      for (int e = 0; e <= 9; e++) begin
        if (e <= 8) begin
          locked_frame(24, e, 1'(p), 10 + p * 16 + e, (e % 3) != 2);
        end else begin
          frame(24, e, 1'(p), 40 + p);
          repeat (4) @(negedge clk);
          check(dec_req == 1'b0, "R4 nine sync errors rejected", 112'(dec_req), 112'(0));
          do_reset();
          @(negedge clk);
          check({op, arg, unit_id} == 32'h0, "R1 fields cleared by reset",
                112'({op, arg, unit_id}), 112'(0));
        end
      end
    end

    // failed CRC followed by a good frame
    locked_frame(24, 0, 1'b0, 77, 1'b0);
    locked_frame(24, 3, 1'b1, 78, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule